// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block drives a small set of clock outputs, three by default, from three source clocks: a slow clock, a main clock and a PLL clock. Each channel has its own configuration word. A 2-bit selector picks the source and a 3-bit prescaler divides that source by a power of two. Software turns outputs on by writing ones to a set register and off by writing ones to a clear register. It can read back a mask of the active outputs and a mask of per-channel ready flags. A ready flag shows that the channel's divided clock has settled on the settings last written.

The three source levels are brought into the system clock domain through a two-stage synchroniser. Each channel's divider counts the rising edges of its selected synchronised source, so every source must run at less than half the system clock rate. The output does not switch glitch-free. Software should clear a channel's enable, rewrite its configuration, wait for its ready flag and then enable it again. A per-channel lock state machine tracks settling. It has three states:

- LK_ARM waits for the first rising edge of the divided clock after a configuration write or reset.
- LK_MEASURE waits for the next rising edge, so that one complete output period has elapsed.
- LK_LOCKED raises ready.

The state machine has these transitions: ARM→MEASURE on an output rise, MEASURE→LOCKED on an output rise, and any state→ARM on a write to that channel's configuration.

Top module: `ckout_gen`

## Requirements
- R1: Each channel owns a configuration register at address 4+channel. Bits [1:0] hold the source selector and bits [4:2] hold the prescaler. The register reads back as written and resets to 0.
- R2: Source selector 0 picks the slow clock, 1 picks the main clock, and 2 or 3 picks the PLL clock.
- R3: Prescaler value p from 0 to 6 makes the output period 2^p source periods, and 7 acts as 64. For p ≥ 1 the output is high for half of each period. For p = 0 it copies the source waveform.
- R4: A write to address 0 enables every channel whose data bit (bit index = channel) is 1. Zero bits leave that channel's enable unchanged.
- R5: A write to address 1 disables every channel whose data bit is 1. Zero bits leave that channel's enable unchanged.
- R6: Address 2 reads the enable mask, with one bit per channel at bit index = channel.
- R7: A disabled channel holds its output low.
- R8: From the cycle after a configuration write, that channel's ready bit at address 3 (bit index = channel) reads 0. The ready bits of the other channels are unaffected.
- R9: A cleared ready bit returns to 1 on the second rising edge of the new divided clock. This is never earlier than one full new output period after the write, and within two periods plus synchroniser delay.
- R10: After reset all channels are disabled, all configuration words are 0, all ready bits are 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also samples the sources |
| rst_n | input | 1 | Active-low synchronous reset |
| src_slow | input | 1 | Slow source clock level |
| src_main | input | 1 | Main source clock level |
| src_pll | input | 1 | PLL source clock level |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| clk_out | output | NUM_CH | Programmed clock outputs, one per channel |

## Verification
The hardest situation to reach from the ports is the ready flag's timing relative to a configuration write. The flag must stay low through a possibly short first half-period and rise only after a complete new period. To make the expected window exact, the bench runs each source at an integer number of system cycles, with edges offset from the sampling edge. It then counts the cycles from each reconfiguration to the ready flag and checks them against one and two output periods. The reserved prescaler code and the second PLL selector code are each programmed once, so that their periods are measured and not just read back.

// File: rtl/ckout_pkg.sv
`timescale 1ns/100ps
package ckout_pkg;
    localparam int unsigned CH_COUNT      = 3;
    localparam int unsigned SRC_W         = 2;
    localparam int unsigned PRESC_BITS    = 3;
    localparam int unsigned DIV_LOG_LIMIT = 6;

    localparam int unsigned ADDR_ON       = 0;
    localparam int unsigned ADDR_OFF      = 1;
    localparam int unsigned ADDR_ACTIVE   = 2;
    localparam int unsigned ADDR_READY    = 3;
    localparam int unsigned ADDR_CFG_BASE = 4;

    typedef enum logic [1:0] {
        SRC_SLOW    = 2'd0,
        SRC_MAIN    = 2'd1,
        SRC_PLL     = 2'd2,
        SRC_PLL_ALT = 2'd3
    } src_sel_t;

    typedef enum logic [1:0] {
        LK_ARM     = 2'd0,
        LK_MEASURE = 2'd1,
        LK_LOCKED  = 2'd2
    } lock_state_t;
endpackage

// File: rtl/ckout_regs.sv
`timescale 1ns/100ps
module ckout_regs
    import ckout_pkg::*;
#(
    parameter int unsigned NUM_CH  = CH_COUNT,
    parameter int unsigned ADDR_W  = 3,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned PRESC_W = PRESC_BITS
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_wr,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    input  logic [NUM_CH-1:0]                ready,
    output logic [DATA_W-1:0]                bus_rdata,
    output logic [NUM_CH-1:0]                en_q,
    output logic [NUM_CH-1:0][SRC_W-1:0]     src_q,
    output logic [NUM_CH-1:0][PRESC_W-1:0]   presc_q,
    output logic [NUM_CH-1:0]                cfg_wr
);
    localparam int unsigned CFG_W = SRC_W + PRESC_W;

    logic              wr_on;
    logic              wr_off;
    logic [NUM_CH-1:0] set_mask;
    logic [NUM_CH-1:0] clr_mask;

    assign wr_on    = bus_wr && (bus_addr == ADDR_W'(ADDR_ON));
    assign wr_off   = bus_wr && (bus_addr == ADDR_W'(ADDR_OFF));
    assign set_mask = wr_on  ? bus_wdata[NUM_CH-1:0] : '0;
    assign clr_mask = wr_off ? bus_wdata[NUM_CH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= (en_q | set_mask) & ~clr_mask;
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_cfg
        assign cfg_wr[i] = bus_wr && (bus_addr == ADDR_W'(ADDR_CFG_BASE + i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q[i]   <= '0;
                presc_q[i] <= '0;
            end else if (cfg_wr[i]) begin
                src_q[i]   <= bus_wdata[SRC_W-1:0];
                presc_q[i] <= bus_wdata[CFG_W-1:SRC_W];
            end
        end

        // R4
        on_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_on && bus_wdata[i]) |=> en_q[i]);
        // R5
        off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_off && bus_wdata[i]) |=> !en_q[i]);
        // R4
        zero_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((wr_on || wr_off) && !bus_wdata[i]) |=> $stable(en_q[i]));
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADDR_ACTIVE)) begin
            bus_rdata[NUM_CH-1:0] = en_q;
        end else if (bus_addr == ADDR_W'(ADDR_READY)) begin
            bus_rdata[NUM_CH-1:0] = ready;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_addr == ADDR_W'(ADDR_CFG_BASE + i)) begin
                    bus_rdata[CFG_W-1:0] = {presc_q[i], src_q[i]};
                end
            end
        end
    end
endmodule

// File: rtl/ckout_div.sv
`timescale 1ns/100ps
module ckout_div
    import ckout_pkg::*;
#(
    parameter int unsigned PRESC_W     = PRESC_BITS,
    parameter int unsigned DIV_LOG_MAX = DIV_LOG_LIMIT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               lvl_slow,
    input  logic               lvl_main,
    input  logic               lvl_pll,
    input  logic [SRC_W-1:0]   src_sel,
    input  logic [PRESC_W-1:0] presc,
    output logic               div_clk
);
    localparam int unsigned CNT_W = (DIV_LOG_MAX > 1) ? DIV_LOG_MAX - 1 : 1;

    logic               sel_lvl;
    logic               prev_q;
    logic               rise;
    logic [PRESC_W-1:0] log_eff;
    logic [CNT_W-1:0]   half_m1;
    logic [CNT_W-1:0]   cnt_q;

    always_comb begin
        unique case (src_sel_t'(src_sel))
            SRC_SLOW:             sel_lvl = lvl_slow;
            SRC_MAIN:             sel_lvl = lvl_main;
            SRC_PLL, SRC_PLL_ALT: sel_lvl = lvl_pll;
            default:              sel_lvl = lvl_pll;
        endcase
    end

    assign log_eff = (presc > PRESC_W'(DIV_LOG_MAX)) ? PRESC_W'(DIV_LOG_MAX) : presc;
    assign rise    = sel_lvl & ~prev_q;

    always_comb begin
        half_m1 = '0;
        if (log_eff != '0) begin
            half_m1 = CNT_W'((32'd1 << (log_eff - 1'b1)) - 32'd1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            prev_q  <= sel_lvl;
            cnt_q   <= '0;
            div_clk <= 1'b0;
        end else begin
            prev_q <= sel_lvl;
            if (log_eff == '0) begin
                div_clk <= sel_lvl;
            end else if (rise) begin
                if (cnt_q == half_m1) begin
                    cnt_q   <= '0;
                    div_clk <= ~div_clk;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R3
    half_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (log_eff != '0) |-> (cnt_q <= half_m1));
endmodule

// File: rtl/ckout_lock.sv
`timescale 1ns/100ps
module ckout_lock
    import ckout_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic div_clk,
    output logic ready
);
    lock_state_t state_q;
    lock_state_t state_d;
    logic        prev_q;
    logic        out_rise;

    assign out_rise = div_clk & ~prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            state_q <= LK_ARM;
            prev_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            prev_q  <= div_clk;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_ARM:     if (out_rise) state_d = LK_MEASURE;
            LK_MEASURE: if (out_rise) state_d = LK_LOCKED;
            LK_LOCKED:  state_d = LK_LOCKED;
            default:    state_d = LK_ARM;
        endcase
    end

    always_comb begin
        ready = (state_q == LK_LOCKED);
    end

    // R8
    wr_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !ready);
    // R9
    ready_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(div_clk));
    // R9
    no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_ARM) |=> (state_q != LK_LOCKED));
endmodule

// File: rtl/ckout_gen.sv
`timescale 1ns/100ps
module ckout_gen
    import ckout_pkg::*;
#(
    parameter int unsigned NUM_CH      = CH_COUNT,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned PRESC_W     = PRESC_BITS,
    parameter int unsigned DIV_LOG_MAX = DIV_LOG_LIMIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_slow,
    input  logic              src_main,
    input  logic              src_pll,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] clk_out
);
    localparam int unsigned NUM_SRC = 3;

    logic [NUM_SRC-1:0]              sync_a;
    logic [NUM_SRC-1:0]              sync_b;
    logic [NUM_CH-1:0]               en_q;
    logic [NUM_CH-1:0]               cfg_wr;
    logic [NUM_CH-1:0]               ready;
    logic [NUM_CH-1:0]               div_clk;
    logic [NUM_CH-1:0][SRC_W-1:0]    src_q;
    logic [NUM_CH-1:0][PRESC_W-1:0]  presc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= '0;
            sync_b <= '0;
        end else begin
            sync_a <= {src_pll, src_main, src_slow};
            sync_b <= sync_a;
        end
    end

    ckout_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PRESC_W(PRESC_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .ready    (ready),
        .bus_rdata(bus_rdata),
        .en_q     (en_q),
        .src_q    (src_q),
        .presc_q  (presc_q),
        .cfg_wr   (cfg_wr)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ckout_div #(
            .PRESC_W    (PRESC_W),
            .DIV_LOG_MAX(DIV_LOG_MAX)
        ) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (cfg_wr[i]),
            .lvl_slow(sync_b[0]),
            .lvl_main(sync_b[1]),
            .lvl_pll (sync_b[2]),
            .src_sel (src_q[i]),
            .presc   (presc_q[i]),
            .div_clk (div_clk[i])
        );

        ckout_lock u_lock (
            .clk    (clk),
            .rst_n  (rst_n),
            .restart(cfg_wr[i]),
            .div_clk(div_clk[i]),
            .ready  (ready[i])
        );

        assign clk_out[i] = en_q[i] & div_clk[i];

        // R7
        off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(en_q[i]) && !en_q[i]) |-> !clk_out[i]);
    end
endmodule

// File: tb/tb_ckout_gen.sv
`timescale 1ns/100ps
module tb_ckout_gen;
    localparam int NCH = 3;
    localparam int AW  = 3;
    localparam int DW  = 8;
    localparam int P_PLL  = 4;
    localparam int P_MAIN = 6;
    localparam int P_SLOW = 10;

    typedef struct {
        int ch;
        int period;
        int high;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic src_slow = 1'b0, src_main = 1'b0, src_pll = 1'b0;
    logic bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NCH-1:0] clk_out;

    exp_t sb_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    ckout_gen dut (
        .clk(clk), .rst_n(rst_n),
        .src_slow(src_slow), .src_main(src_main), .src_pll(src_pll),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .clk_out(clk_out)
    );

    always #2.5 clk = ~clk;
    initial begin #1; forever #10 src_pll  = ~src_pll;  end
    initial begin #1; forever #15 src_main = ~src_main; end
    initial begin #1; forever #25 src_slow = ~src_slow; end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_range(string req, int act, int lo, int hi);
        n_cmp++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic bus_write(int addr, int data);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = AW'(addr);
        bus_wdata = DW'(data);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(int addr, output int data);
        @(negedge clk);
        bus_addr = AW'(addr);
        #1;
        data = int'(bus_rdata);
    endtask

    // driver: reprogram one channel following the disable/write/wait/enable protocol
    task automatic configure(int ch, int src, int p, int src_per);
        int d, n, eff, per, cfg;
        eff = (p > 6) ? 6 : p;
        per = src_per << eff;
        cfg = src | (p << 2);
        bus_write(1, 1 << ch);
        bus_write(4 + ch, cfg);
        n = 0;
        bus_read(3, d);
        n++;
        check("R8 ready cleared after config write", (d >> ch) & 1, 0);
        while (((d >> ch) & 1) == 0 && n < 4000) begin
            bus_read(3, d);
            n++;
        end
        check_range("R9 write-to-ready cycles", n, per, 2 * per + 8);
        bus_read(4 + ch, d);
        check("R1 config readback", d, cfg);
        bus_write(0, 1 << ch);
        sb_q.push_back('{ch: ch, period: per, high: (eff == 0) ? src_per / 2 : per / 2});
        wait (sb_q.size() == 0);
    endtask

    // monitor: measure one high phase and one full period of the expected channel
    initial begin
        forever begin
            exp_t e;
            int h, l;
            wait (sb_q.size() != 0);
            e = sb_q[0];
            @(negedge clk);
            while (clk_out[e.ch] !== 1'b0) @(negedge clk);
            while (clk_out[e.ch] !== 1'b1) @(negedge clk);
            h = 0;
            while (clk_out[e.ch] === 1'b1) begin @(negedge clk); h++; end
            l = 0;
            while (clk_out[e.ch] === 1'b0) begin @(negedge clk); l++; end
            check("R3 output high time", h, e.high);
            check("R3 output period", h + l, e.period);
            void'(sb_q.pop_front());
        end
    end

    initial begin
        int d, highs;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        bus_read(2, d); check("R10 active mask after reset", d, 0);
        bus_read(3, d); check("R10 ready mask after reset", d, 0);
        bus_read(4, d); check("R10 config 0 after reset", d, 0);
        bus_read(6, d); check("R10 config 2 after reset", d, 0);
        check("R10 outputs low after reset", int'(clk_out), 0);
        d = 0;
        while (d != 7) bus_read(3, d);

        // R2 R3 pll divide by 1, slow divide by 4, main divide by 8
        configure(0, 2, 0, P_PLL);
        bus_read(2, d); check("R6 active mask ch0", d, 1);
        configure(2, 0, 2, P_SLOW);
        configure(1, 1, 3, P_MAIN);
        // R8 other channels keep ready
        bus_write(4 + 1, 1 | (1 << 2));
        bus_read(3, d); check("R8 neighbour ready kept", d & 5, 5);
        configure(1, 1, 1, P_MAIN);
        bus_read(2, d); check("R6 active mask all", d, 7);
        // R2 selector 3 is PLL, R3 reserved prescaler 7 acts as 64
        configure(0, 3, 6, P_PLL);
        configure(2, 2, 7, P_PLL);

        // R4 zero bits on the enable register change nothing
        bus_write(0, 0);
        bus_read(2, d); check("R4 zero write keeps mask", d, 7);
        // R5 disable only channel 1
        bus_write(1, 2);
        bus_read(2, d); check("R5 clear ch1 only", d, 5);
        bus_write(1, 0);
        bus_read(2, d); check("R5 zero write keeps mask", d, 5);
        // R7 disabled output stays low
        highs = 0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (clk_out[1] !== 1'b0) highs++;
        end
        check("R7 disabled output high samples", highs, 0);
        bus_write(0, 2);
        bus_read(2, d); check("R4 re-enable ch1", d, 7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule